// File: doc/BRIEF.md
# SD Host Single-Operation DMA Engine

This block is the simple-DMA part of an SD host controller. Software programs a start address, a per-block byte count with a buffer-boundary size code, a block count, and a transfer mode. Writing the transfer mode with its DMA-enable bit set launches the transfer. The engine then moves one 32-bit word per memory handshake. In one direction it takes words from the card-data stream and writes them to memory. In the other it reads words from memory and hands them to the card-data stream.

The address rises by four bytes per word. When the next address lands on a multiple of the programmed boundary and words are still left, the engine stalls and flags a DMA interrupt. Software resumes the transfer by rewriting the address register, and the engine continues from the new value. The end of the last block sets a transfer-complete flag. The status flags are write-one-to-clear, can each be gated off by a status enable, and drive one interrupt line through a second mask.

Top module: `sdma_engine`

## Requirements
- R1: After reset every register reads zero, `irq_o` is low and no memory request is made. Register indices are: 0 address, 1 block size, 2 block count, 3 transfer mode, 4 host control, 5 status, 6 status enable, 7 signal enable.
- R2: A write to register 3 with bit 0 set, made while idle and while host-control bits [4:3] are 00, starts a transfer. Each memory handshake (`mem_req_o` and `mem_ack_i`) moves one word. Addresses start at the address register and rise by 4 per word.
- R3: Transfer-mode bit 4 sets the direction. With bit 4 = 1 the engine writes card-stream words to memory (`mem_we_o` high, `mem_wdata_o` = `card_data_i`). With bit 4 = 0 it reads memory and presents `mem_rdata_i` on `card_data_o` with `card_valid_o` high.
- R4: Block size is register 1 bits [11:0], in bytes. With mode bit 5 (multi-block) clear, exactly one block is moved. With bit 5 set and bit 1 (count enable) set, register 2 drops by one per finished block and the transfer ends when it reaches zero.
- R5: When the last block finishes, status bit 1 is set.
- R6: The boundary is 4096 << (register 1 bits [14:12]) bytes. If a word leaves the next address on a boundary multiple and the transfer is not finished, the engine stops requesting and sets status bit 3. Register 0 then reads that next address.
- R7: While stalled, a write to register 0 resumes the transfer from the written address.
- R8: Writing register 5 clears each status bit written as one and leaves the others.
- R9: A status bit latches only if the same bit of register 6 is set. `irq_o` is the OR of the status bits that are also set in register 7.
- R10: A start request while host-control bits [4:3] are not 00 moves no data and sets status bit 15 (error summary).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with `mem_ack_i` |
| mem_ack_i | input | 1 | Memory accepts the request this cycle |
| card_valid_i | input | 1 | Card stream has a word for memory |
| card_data_i | input | 32 | Card stream word |
| card_ready_o | output | 1 | Engine takes `card_data_i` |
| card_valid_o | output | 1 | Engine offers a word to the card stream |
| card_data_o | output | 32 | Word to the card stream |
| card_ready_i | input | 1 | Card stream can take a word |
| irq_o | output | 1 | Interrupt line |

## Verification
The assertions assume that the block size is a nonzero multiple of four bytes. They assume that a counted multi-block transfer starts with a nonzero block count. They also assume that software leaves the size, count and mode fields alone while a transfer runs. The stimulus programs every transfer from idle with sizes of 8 or 16 bytes and counts of at least one. It holds the memory and card handshakes permanently ready, so one word moves per cycle and the stall and resume points fall on known cycles.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam int BLK_SZ_W = 12;
  localparam int BND_LG   = 12;

  localparam logic [2:0] REG_ADDR  = 3'd0;
  localparam logic [2:0] REG_BLKSZ = 3'd1;
  localparam logic [2:0] REG_CNT   = 3'd2;
  localparam logic [2:0] REG_MODE  = 3'd3;
  localparam logic [2:0] REG_HCTL  = 3'd4;
  localparam logic [2:0] REG_STS   = 3'd5;
  localparam logic [2:0] REG_STSEN = 3'd6;
  localparam logic [2:0] REG_SIGEN = 3'd7;

  localparam int STS_DONE = 1;
  localparam int STS_DMA  = 3;
  localparam int STS_ERR  = 15;

  localparam int MODE_DMA   = 0;
  localparam int MODE_CNTEN = 1;
  localparam int MODE_RD    = 4;
  localparam int MODE_MULTI = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_STALL} xfer_state_e;
endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
  import sdma_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [2:0]          addr_i,
  input  logic [31:0]         wdata_i,
  input  logic                busy_i,
  input  logic [15:0]         set_i,
  output logic [BLK_SZ_W-1:0] blk_size_o,
  output logic [2:0]          bnd_code_o,
  output logic [5:0]          mode_o,
  output logic [7:0]          hctl_o,
  output logic [15:0]         sts_o,
  output logic [15:0]         sts_en_o,
  output logic [15:0]         sig_en_o,
  output logic                irq_o
);
  localparam logic [5:0] MODE_MASK = 6'b110111;

  logic [15:0] clr;
  assign clr = (we_i && addr_i == REG_STS) ? wdata_i[15:0] : 16'h0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_size_o <= '0;
      bnd_code_o <= '0;
      mode_o     <= '0;
      hctl_o     <= '0;
      sts_o      <= '0;
      sts_en_o   <= '0;
      sig_en_o   <= '0;
    end else begin
      sts_o <= (sts_o & ~clr) | (set_i & sts_en_o);
      if (we_i) begin
        unique case (addr_i)
          REG_BLKSZ: if (!busy_i) begin
            blk_size_o <= wdata_i[BLK_SZ_W-1:0];
            bnd_code_o <= wdata_i[14:12];
          end
          REG_MODE:  if (!busy_i) mode_o <= wdata_i[5:0] & MODE_MASK;
          REG_HCTL:  hctl_o   <= wdata_i[7:0];
          REG_STSEN: sts_en_o <= wdata_i[15:0];
          REG_SIGEN: sig_en_o <= wdata_i[15:0];
          default: ;
        endcase
      end
    end
  end

  assign irq_o = |(sts_o & sig_en_o);

  a_r8_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_STS && wdata_i[STS_DMA] && !set_i[STS_DMA]) |=> !sts_o[STS_DMA]);
  a_r9_gated_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sts_o[STS_DONE] && !sts_en_o[STS_DONE]) |=> !sts_o[STS_DONE]);
endmodule

// File: rtl/sdma_ctrl.sv
module sdma_ctrl
  import sdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                addr_we_i,
  input  logic                cnt_we_i,
  input  logic [31:0]         wdata_i,
  input  logic                start_i,
  input  logic                dir_rd_i,
  input  logic                cnt_en_i,
  input  logic                multi_i,
  input  logic [BLK_SZ_W-1:0] blk_size_i,
  input  logic [2:0]          bnd_code_i,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  input  logic                mem_ack_i,
  input  logic                card_valid_i,
  input  logic [DATA_W-1:0]   card_data_i,
  output logic                card_ready_o,
  output logic                card_valid_o,
  output logic [DATA_W-1:0]   card_data_o,
  input  logic                card_ready_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [CNT_W-1:0]    cnt_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                stall_o
);
  localparam int BYTES = DATA_W / 8;
  localparam int OFF_W = BLK_SZ_W + 1;

  xfer_state_e       state_q;
  logic [ADDR_W-1:0] addr_q, addr_nx, bnd_mask;
  logic [CNT_W-1:0]  cnt_q;
  logic [OFF_W-1:0]  off_q, off_nx;
  logic              xfer, fire, blk_end, last, at_bnd;

  assign xfer        = state_q == ST_XFER;
  assign mem_req_o   = xfer && (dir_rd_i ? card_valid_i : card_ready_i);
  assign fire        = mem_req_o && mem_ack_i;
  assign mem_we_o    = dir_rd_i;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = card_data_i;
  assign card_ready_o = xfer && dir_rd_i && mem_ack_i;
  assign card_valid_o = xfer && !dir_rd_i && mem_ack_i;
  assign card_data_o  = mem_rdata_i;

  assign addr_nx  = addr_q + ADDR_W'(BYTES);
  assign off_nx   = off_q + OFF_W'(BYTES);
  assign blk_end  = off_nx >= {1'b0, blk_size_i};
  assign last     = blk_end && (!multi_i || (cnt_en_i && cnt_q == CNT_W'(1)));
  assign bnd_mask = (ADDR_W'(1) << (BND_LG + int'(bnd_code_i))) - ADDR_W'(1);
  assign at_bnd   = (addr_nx & bnd_mask) == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      cnt_q   <= '0;
      off_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (addr_we_i) addr_q <= wdata_i[ADDR_W-1:0];
          if (cnt_we_i)  cnt_q  <= wdata_i[CNT_W-1:0];
          if (start_i) begin
            state_q <= ST_XFER;
            off_q   <= '0;
          end
        end
        ST_XFER: if (fire) begin
          addr_q <= addr_nx;
          off_q  <= blk_end ? '0 : off_nx;
          if (blk_end && cnt_en_i && cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
          if (last)        state_q <= ST_IDLE;
          else if (at_bnd) state_q <= ST_STALL;
        end
        ST_STALL: if (addr_we_i) begin
          addr_q  <= wdata_i[ADDR_W-1:0];
          state_q <= ST_XFER;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign addr_o  = addr_q;
  assign cnt_o   = cnt_q;
  assign busy_o  = state_q != ST_IDLE;
  assign done_o  = fire && last;
  assign stall_o = fire && !last && at_bnd;

  a_r2_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> addr_q == $past(addr_q) + ADDR_W'(BYTES));
  a_r6_stall_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STALL) |-> (addr_q & bnd_mask) == '0);
  a_r7_stall_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STALL && !addr_we_i) |=> !mem_req_o);
  a_r4_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && blk_end && cnt_en_i && multi_i) |-> cnt_q != '0);
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
  import sdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  input  logic              mem_ack_i,
  input  logic              card_valid_i,
  input  logic [31:0]       card_data_i,
  output logic              card_ready_o,
  output logic              card_valid_o,
  output logic [31:0]       card_data_o,
  input  logic              card_ready_i,
  output logic              irq_o
);
  logic [BLK_SZ_W-1:0] blk_size;
  logic [2:0]          bnd_code;
  logic [5:0]          mode;
  logic [7:0]          hctl;
  logic [15:0]         sts, sts_en, sig_en, set;
  logic [ADDR_W-1:0]   addr;
  logic [CNT_W-1:0]    cnt;
  logic                busy, done, stall, go, sel_ok, start, bad_start;

  assign go        = reg_we_i && reg_addr_i == REG_MODE && reg_wdata_i[MODE_DMA] && !busy;
  assign sel_ok    = hctl[4:3] == 2'b00;
  assign start     = go && sel_ok;
  assign bad_start = go && !sel_ok;

  always_comb begin
    set           = '0;
    set[STS_DONE] = done;
    set[STS_DMA]  = stall;
    set[STS_ERR]  = bad_start;
  end

  sdma_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .busy_i(busy), .set_i(set),
    .blk_size_o(blk_size), .bnd_code_o(bnd_code), .mode_o(mode), .hctl_o(hctl),
    .sts_o(sts), .sts_en_o(sts_en), .sig_en_o(sig_en), .irq_o(irq_o)
  );

  sdma_ctrl #(.ADDR_W(ADDR_W), .DATA_W(32), .CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni,
    .addr_we_i(reg_we_i && reg_addr_i == REG_ADDR),
    .cnt_we_i(reg_we_i && reg_addr_i == REG_CNT),
    .wdata_i(reg_wdata_i), .start_i(start),
    .dir_rd_i(mode[MODE_RD]), .cnt_en_i(mode[MODE_CNTEN]), .multi_i(mode[MODE_MULTI]),
    .blk_size_i(blk_size), .bnd_code_i(bnd_code),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i, .mem_ack_i,
    .card_valid_i, .card_data_i, .card_ready_o, .card_valid_o, .card_data_o, .card_ready_i,
    .addr_o(addr), .cnt_o(cnt), .busy_o(busy), .done_o(done), .stall_o(stall)
  );

  always_comb begin
    unique case (reg_addr_i)
      REG_ADDR:  reg_rdata_o = 32'(addr);
      REG_BLKSZ: reg_rdata_o = {17'b0, bnd_code, blk_size};
      REG_CNT:   reg_rdata_o = 32'(cnt);
      REG_MODE:  reg_rdata_o = {26'b0, mode};
      REG_HCTL:  reg_rdata_o = {24'b0, hctl};
      REG_STS:   reg_rdata_o = {16'b0, sts};
      REG_STSEN: reg_rdata_o = {16'b0, sts_en};
      default:   reg_rdata_o = {16'b0, sig_en};
    endcase
  end

  a_r10_bad_sel_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_start |=> !mem_req_o);
  a_r1_idle_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mem_req_o);
endmodule

// File: tb/sdma_engine_test.sv
module sdma_engine_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, card_ready, card_valid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, card_data_in, card_data_out;
  logic        irq;

  int checks = 0, fails = 0;
  int fire_cnt = 0, data_bad = 0;
  logic [31:0] addr_log [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata    = mem_addr ^ 32'h5A5A_0000;
  assign card_data_in = ~mem_addr;

  sdma_engine uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ack_i(1'b1),
    .card_valid_i(1'b1), .card_data_i(card_data_in), .card_ready_o(card_ready),
    .card_valid_o(card_valid), .card_data_o(card_data_out), .card_ready_i(1'b1),
    .irq_o(irq)
  );

  // word monitor: one handshake per negedge observed
  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      addr_log[fire_cnt % 32] = mem_addr;
      if (mem_we) begin
        if (!card_ready || mem_wdata !== ~mem_addr) data_bad++;
      end else begin
        if (!card_valid || card_data_out !== (mem_addr ^ 32'h5A5A_0000)) data_bad++;
      end
      fire_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), v);
      chk(v == 0, "R1 reg zero", v, 0);
    end
    chk(!irq && !mem_req, "R1 irq/req low", {30'b0, irq, mem_req}, 0);
  endtask

  task automatic t_single_write();
    logic [31:0] v;
    int f0, b0;
    wr(3'd6, 32'h800A);
    wr(3'd0, 32'h100);
    wr(3'd1, 32'd16);
    wr(3'd2, 32'd1);
    f0 = fire_cnt; b0 = data_bad;
    wr(3'd3, 32'h03);
    settle();
    chk(fire_cnt - f0 == 4, "R2 word count", fire_cnt - f0, 4);
    chk(addr_log[f0 % 32] == 32'h100 && addr_log[(f0 + 3) % 32] == 32'h10C, "R2 address order",
        addr_log[(f0 + 3) % 32], 32'h10C);
    chk(data_bad == b0, "R3 memory to card data", data_bad - b0, 0);
    rd(3'd0, v);
    chk(v == 32'h110, "R2 address after", v, 32'h110);
    rd(3'd5, v);
    chk(v == 32'h2, "R5 complete bit", v, 32'h2);
    wr(3'd5, 32'h2);
  endtask

  task automatic t_multi_read();
    logic [31:0] v;
    int f0, b0;
    wr(3'd0, 32'h400);
    wr(3'd1, 32'd8);
    wr(3'd2, 32'd3);
    f0 = fire_cnt; b0 = data_bad;
    wr(3'd3, 32'h33);
    settle();
    chk(fire_cnt - f0 == 6, "R4 counted blocks", fire_cnt - f0, 6);
    chk(data_bad == b0 && addr_log[(f0 + 5) % 32] == 32'h414, "R3 card to memory data",
        addr_log[(f0 + 5) % 32], 32'h414);
    rd(3'd2, v);
    chk(v == 0, "R4 count reaches zero", v, 0);
    rd(3'd5, v);
    chk(v == 32'h2, "R5 complete after count", v, 32'h2);
    wr(3'd5, 32'h2);
  endtask

  task automatic t_single_flag();
    logic [31:0] v;
    int f0;
    wr(3'd0, 32'h600);
    wr(3'd1, 32'd8);
    wr(3'd2, 32'd3);
    f0 = fire_cnt;
    wr(3'd3, 32'h13);
    settle();
    chk(fire_cnt - f0 == 2, "R4 single block", fire_cnt - f0, 2);
    rd(3'd2, v);
    chk(v == 2, "R4 count decrement", v, 2);
    wr(3'd5, 32'h2);
  endtask

  task automatic t_boundary();
    logic [31:0] v;
    int f0;
    wr(3'd7, 32'h8);
    wr(3'd0, 32'hFF8);
    wr(3'd1, 32'd16);
    wr(3'd2, 32'd1);
    f0 = fire_cnt;
    wr(3'd3, 32'h13);
    settle();
    chk(fire_cnt - f0 == 2, "R6 stall words", fire_cnt - f0, 2);
    chk(!mem_req, "R6 no request while stalled", {31'b0, mem_req}, 0);
    rd(3'd0, v);
    chk(v == 32'h1000, "R6 next address", v, 32'h1000);
    rd(3'd5, v);
    chk(v == 32'h8, "R6 dma flag only", v, 32'h8);
    chk(irq, "R9 irq from dma flag", {31'b0, irq}, 1);
    wr(3'd0, 32'h2000);
    settle();
    chk(fire_cnt - f0 == 4 && addr_log[(f0 + 2) % 32] == 32'h2000, "R7 resume address",
        addr_log[(f0 + 2) % 32], 32'h2000);
    rd(3'd5, v);
    chk(v == 32'hA, "R7 completes", v, 32'hA);
    wr(3'd5, 32'h8);
    rd(3'd5, v);
    chk(v == 32'h2, "R8 write one clears", v, 32'h2);
    chk(!irq, "R9 irq masked", {31'b0, irq}, 0);
    wr(3'd5, 32'h2);
  endtask

  task automatic t_wide_boundary();
    logic [31:0] v;
    int f0;
    wr(3'd0, 32'hFF8);
    wr(3'd1, 32'h1010);
    f0 = fire_cnt;
    wr(3'd3, 32'h13);
    settle();
    chk(fire_cnt - f0 == 4, "R6 larger boundary no stall", fire_cnt - f0, 4);
    rd(3'd5, v);
    chk(v == 32'h2, "R6 no dma flag", v, 32'h2);
    wr(3'd5, 32'h2);
  endtask

  task automatic t_gate();
    logic [31:0] v;
    wr(3'd6, 32'h8008);
    wr(3'd0, 32'h700);
    wr(3'd1, 32'd8);
    wr(3'd3, 32'h13);
    settle();
    rd(3'd5, v);
    chk(v == 0, "R9 disabled status not latched", v, 0);
    wr(3'd6, 32'h800A);
  endtask

  task automatic t_bad_sel();
    logic [31:0] v;
    int f0;
    wr(3'd4, 32'h10);
    f0 = fire_cnt;
    wr(3'd3, 32'h13);
    settle();
    chk(fire_cnt == f0, "R10 no transfer", fire_cnt - f0, 0);
    rd(3'd5, v);
    chk(v == 32'h8000, "R10 error flag", v, 32'h8000);
    wr(3'd5, 32'h8000);
    wr(3'd4, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_write();
    t_multi_read();
    t_single_flag();
    t_boundary();
    t_wide_boundary();
    t_gate();
    t_bad_sel();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule